// File: doc/BRIEF.md
# Dual-Width Byte-Lane Steering Unit

This block sits between a system bus that moves either one byte or a two-byte word per transfer and a store built from four 16 KB banks. The banks form two pairs, and each pair has an even lane and an odd lane. From a few address bits, a wide-transfer request, two configuration straps and the board selects, the unit produces four active-low bank chip selects. It also produces three active-low read-path output enables, two active-low write-source enables for the odd lane, and an active-low wide-transfer acknowledge.

The unit has two arrangements. In the interleaved arrangement the even and odd lanes of a pair share the same word address, so a wide transfer uses both lanes at once. In the byte-only arrangement the four banks are separate byte banks that follow one another in the address space. A second strap turns wide-transfer support off altogether. The two odd-lane write sources feed a shared node, so when the selected source changes, both enables go off for one clock before the new one comes on.

Top module: `lane_steer`

## Requirements
- R1: Interleaved arrangement with no wide transfer honoured: `addrTop[1]` (address bit 15) picks the pair and `addrLsb` picks the lane (0 even, 1 odd). Exactly one chip select is low. The `csN` bit order is bit0 pair0-even, bit1 pair0-odd, bit2 pair1-even, bit3 pair1-odd.
- R2: Interleaved arrangement, `wideEn`=1 and `wideReqN`=0: both chip selects of the pair picked by `addrTop[1]` are low, whatever `addrLsb` is.
- R3: Byte-only arrangement: `addrTop` (address bits 15..14) selects `csN` bit index 0, 1, 2 or 3 for values 00, 01, 10, 11. Exactly that bit is low.
- R4: While `earlySel`=0 or `phantom`=1, `csN` is 4'b1111.
- R5: Interleaved arrangement with reads enabled. With a wide transfer, `rdEvenOutN` and `rdOddInN` are low and `rdEvenInN` is high. Without one, `rdEvenInN` is low when `addrLsb`=0 and `rdOddInN` is low when `addrLsb`=1, and only that one is low.
- R6: Byte-only arrangement: `rdEvenOutN` is never low. With reads enabled, `addrTop[0]`=0 drives `rdEvenInN` low and `addrTop[0]`=1 drives `rdOddInN` low.
- R7: All three read enables stay high unless `readStrobe`=1, `qualSel`=1 and `phantom`=0.
- R8: The odd lane's wanted write source is the input bus (`wrOddFromInN`) during an honoured wide transfer, and the output bus (`wrOddFromOutN`) otherwise. After reset the output-bus source is on. When the wanted source changes before clock edge k, the old enable is high after edge k and the new enable is low after edge k+1.
- R9: `wrOddFromOutN` and `wrOddFromInN` are never low together, and a newly asserted enable always follows at least one clock with both high.
- R10: With `wideEn`=0, `wideReqN` has no effect on any output, and `wideAckN` stays high. In the byte-only arrangement `wideReqN` is also ignored.
- R11: `wideAckN` is low exactly when `qualSel`=1, `phantom`=0, `interleaved`=1, `wideEn`=1 and `wideReqN`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrTop | input | 2 | Address bits 15..14 |
| addrLsb | input | 1 | Address bit 0 |
| earlySel | input | 1 | Address-only board select (not status qualified) |
| qualSel | input | 1 | Status-qualified memory-cycle select |
| phantom | input | 1 | Overlay override, active high; disables the unit |
| readStrobe | input | 1 | Bus read strobe, active high |
| wideReqN | input | 1 | Wide-transfer request, active low |
| interleaved | input | 1 | Strap: 1 interleaved pairs, 0 four byte banks |
| wideEn | input | 1 | Strap: 1 honour wide requests |
| csN | output | 4 | Bank chip selects, active low |
| rdEvenOutN | output | 1 | Even lane onto the low (output) bus, active low |
| rdEvenInN | output | 1 | Even lane onto the input bus, active low |
| rdOddInN | output | 1 | Odd lane onto the input bus, active low |
| wrOddFromOutN | output | 1 | Odd-lane write data from output bus, active low |
| wrOddFromInN | output | 1 | Odd-lane write data from input bus, active low |
| wideAckN | output | 1 | Wide-transfer acknowledge, active low |

## Verification
The only internal state is the odd-lane source sequencer. If it is wrong, the fault shows at the two write-source pins. A source that stays on after a switch would appear with both enables low one clock after the request changes. A missing dead cycle would appear as a new enable low right after the first edge instead of the second. The bench's model predicts both enables on every clock, so a sequencer fault is reported within two cycles of the wide request changing. Decode faults are combinational and are reported in the same cycle as the stimulus.

// File: rtl/lane_pkg.sv
`timescale 1ns/1ps
package lane_pkg;
  localparam int LANES = 2;

  typedef struct packed {
    logic [3:0] csSel;      // active-high bank selects
    logic       rdEvenOut;  // even lane -> output bus
    logic       rdEvenIn;   // even lane -> input bus
    logic       rdOddIn;    // odd lane -> input bus
    logic       ack;        // wide transfer acknowledged
    logic       wantOddIn;  // odd lane should take input-bus data
  } laneStrobes_t;

  typedef enum logic {SRC_OUTBUS = 1'b0, SRC_INBUS = 1'b1} oddSrc_t;
endpackage

// File: rtl/lane_decode.sv
`timescale 1ns/1ps
module lane_decode
  import lane_pkg::*;
#(
  parameter int PAIRS = 2
) (
  input  logic [$clog2(PAIRS*LANES)-1:0] addrTop,
  input  logic                           addrLsb,
  input  logic                           earlySel,
  input  logic                           qualSel,
  input  logic                           phantom,
  input  logic                           readStrobe,
  input  logic                           wideReqN,
  input  logic                           interleaved,
  input  logic                           wideEn,
  output laneStrobes_t                   strobes
);
  localparam int NUM_CS = PAIRS * LANES;
  localparam int SEL_W  = $clog2(NUM_CS);

  logic wideLive;
  logic evenLane;
  logic oddLane;
  logic csGate;
  logic rdGate;
  logic [SEL_W-2:0] pairIdx;

  // A wide request is honoured only when the strap allows it and lanes are paired.
  assign wideLive = interleaved && wideEn && !wideReqN;
  assign pairIdx  = addrTop[SEL_W-1:1];
  assign csGate   = earlySel && !phantom;
  assign rdGate   = readStrobe && qualSel && !phantom;

  always_comb begin
    if (interleaved) begin
      evenLane = wideLive || !addrLsb;
      oddLane  = wideLive ||  addrLsb;
    end else begin
      evenLane = !addrTop[0];
      oddLane  =  addrTop[0];
    end
  end

  for (genvar b = 0; b < NUM_CS; b++) begin : g_cs
    localparam int PAIR_OF = b / LANES;
    localparam bit IS_ODD  = (b % LANES) == 1;
    always_comb begin
      strobes.csSel[b] = csGate && (pairIdx == PAIR_OF[SEL_W-2:0]) &&
                         (IS_ODD ? oddLane : evenLane);
    end
  end

  always_comb begin
    strobes.rdEvenOut = rdGate && wideLive;
    strobes.rdEvenIn  = rdGate && !wideLive && evenLane;
    strobes.rdOddIn   = rdGate && oddLane;
    strobes.ack       = qualSel && !phantom && wideLive;
    strobes.wantOddIn = wideLive;
  end
endmodule

// File: rtl/lane_wrseq.sv
`timescale 1ns/1ps
module lane_wrseq
  import lane_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  laneStrobes_t strobes,
  output logic         oddFromOut,
  output logic         oddFromIn
);
  oddSrc_t curSrc;
  oddSrc_t wantSrc;
  logic    gapOn;

  assign wantSrc = strobes.wantOddIn ? SRC_INBUS : SRC_OUTBUS;

  // A change first opens a one-clock gap, then the new source is enabled.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSrc <= SRC_OUTBUS;
      gapOn  <= 1'b0;
    end else if (gapOn) begin
      gapOn  <= 1'b0;
    end else if (wantSrc != curSrc) begin
      curSrc <= wantSrc;
      gapOn  <= 1'b1;
    end
  end

  assign oddFromOut = !gapOn && (curSrc == SRC_OUTBUS);
  assign oddFromIn  = !gapOn && (curSrc == SRC_INBUS);
endmodule

// File: rtl/lane_steer.sv
`timescale 1ns/1ps
module lane_steer
  import lane_pkg::*;
#(
  parameter int PAIRS = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [$clog2(PAIRS*LANES)-1:0] addrTop,
  input  logic                           addrLsb,
  input  logic                           earlySel,
  input  logic                           qualSel,
  input  logic                           phantom,
  input  logic                           readStrobe,
  input  logic                           wideReqN,
  input  logic                           interleaved,
  input  logic                           wideEn,
  output logic [PAIRS*LANES-1:0]         csN,
  output logic                           rdEvenOutN,
  output logic                           rdEvenInN,
  output logic                           rdOddInN,
  output logic                           wrOddFromOutN,
  output logic                           wrOddFromInN,
  output logic                           wideAckN
);
  laneStrobes_t strobes;
  logic oddFromOut;
  logic oddFromIn;

  lane_decode #(.PAIRS(PAIRS)) u_decode (
    .addrTop(addrTop), .addrLsb(addrLsb), .earlySel(earlySel),
    .qualSel(qualSel), .phantom(phantom), .readStrobe(readStrobe),
    .wideReqN(wideReqN), .interleaved(interleaved), .wideEn(wideEn),
    .strobes(strobes)
  );

  lane_wrseq u_wrseq (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .oddFromOut(oddFromOut), .oddFromIn(oddFromIn)
  );

  assign csN           = ~strobes.csSel[PAIRS*LANES-1:0];
  assign rdEvenOutN    = ~strobes.rdEvenOut;
  assign rdEvenInN     = ~strobes.rdEvenIn;
  assign rdOddInN      = ~strobes.rdOddIn;
  assign wideAckN      = ~strobes.ack;
  assign wrOddFromOutN = ~oddFromOut;
  assign wrOddFromInN  = ~oddFromIn;
endmodule

// File: rtl/lane_steer_checker.sv
`timescale 1ns/1ps
module lane_steer_checker (
  input logic       clk,
  input logic       rstN,
  input logic       earlySel,
  input logic       qualSel,
  input logic       phantom,
  input logic       readStrobe,
  input logic       wideReqN,
  input logic       interleaved,
  input logic       wideEn,
  input logic [3:0] csN,
  input logic       rdEvenOutN,
  input logic       rdEvenInN,
  input logic       rdOddInN,
  input logic       wrOddFromOutN,
  input logic       wrOddFromInN,
  input logic       wideAckN
);
  logic honoured;
  assign honoured = interleaved && wideEn && !wideReqN;

  assert_narrow_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    (earlySel && !phantom && !honoured) |-> $countones(~csN) == 1);

  assert_cs_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!earlySel || phantom) |-> csN == 4'hF);

  assert_byte_no_wide_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    !interleaved |-> rdEvenOutN);

  assert_read_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(readStrobe && qualSel && !phantom) |-> (rdEvenOutN && rdEvenInN && rdOddInN));

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(!wrOddFromOutN && !wrOddFromInN));

  assert_gap_before_in_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrOddFromInN) |-> ($past(wrOddFromInN) && $past(wrOddFromOutN)));

  assert_gap_before_out_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrOddFromOutN) |-> ($past(wrOddFromInN) && $past(wrOddFromOutN)));

  assert_strap_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    !wideEn |-> wideAckN);

  assert_ack_source_R11: assert property (@(posedge clk) disable iff (!rstN)
    !wideAckN |-> (qualSel && !phantom && honoured));
endmodule

bind lane_steer lane_steer_checker u_checker (
  .clk(clk), .rstN(rstN), .earlySel(earlySel), .qualSel(qualSel),
  .phantom(phantom), .readStrobe(readStrobe), .wideReqN(wideReqN),
  .interleaved(interleaved), .wideEn(wideEn), .csN(csN),
  .rdEvenOutN(rdEvenOutN), .rdEvenInN(rdEvenInN), .rdOddInN(rdOddInN),
  .wrOddFromOutN(wrOddFromOutN), .wrOddFromInN(wrOddFromInN),
  .wideAckN(wideAckN)
);

// File: tb/lane_steer_tb.sv
`timescale 1ns/1ps
module lane_steer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] addrTop = 2'b00;
  logic addrLsb = 1'b0, earlySel = 1'b0, qualSel = 1'b0, phantom = 1'b0;
  logic readStrobe = 1'b0, wideReqN = 1'b1, interleaved = 1'b1, wideEn = 1'b1;
  logic [3:0] csN;
  logic rdEvenOutN, rdEvenInN, rdOddInN, wrOddFromOutN, wrOddFromInN, wideAckN;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // model of the odd-lane write source: 0 output bus, 1 input bus
  int srcOn = 0;      // source currently enabled (-1 while in a gap)
  int srcTarget = 0;  // source that will come on after the gap

  always #10 clk = ~clk;

  lane_steer u_dut (
    .clk(clk), .rstN(rstN), .addrTop(addrTop), .addrLsb(addrLsb),
    .earlySel(earlySel), .qualSel(qualSel), .phantom(phantom),
    .readStrobe(readStrobe), .wideReqN(wideReqN), .interleaved(interleaved),
    .wideEn(wideEn), .csN(csN), .rdEvenOutN(rdEvenOutN), .rdEvenInN(rdEvenInN),
    .rdOddInN(rdOddInN), .wrOddFromOutN(wrOddFromOutN),
    .wrOddFromInN(wrOddFromInN), .wideAckN(wideAckN)
  );

  task automatic check(string tag, string what, int actual, int expected);
    tests++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, actual, expected);
    end
  endtask

  function automatic bit wideOk();
    return interleaved && wideEn && !wideReqN;
  endfunction

  // Expected chip selects, written as a table by arrangement
  function automatic logic [3:0] expCs();
    logic [3:0] sel;
    if (!earlySel || phantom) return 4'hF;
    if (!interleaved) begin
      case (addrTop)
        2'b00: sel = 4'b0001;
        2'b01: sel = 4'b0010;
        2'b10: sel = 4'b0100;
        default: sel = 4'b1000;
      endcase
    end else if (wideOk()) begin
      sel = addrTop[1] ? 4'b1100 : 4'b0011;
    end else begin
      case ({addrTop[1], addrLsb})
        2'b00: sel = 4'b0001;
        2'b01: sel = 4'b0010;
        2'b10: sel = 4'b0100;
        default: sel = 4'b1000;
      endcase
    end
    return ~sel;
  endfunction

  // Expected {rdEvenOutN, rdEvenInN, rdOddInN}
  function automatic logic [2:0] expRd();
    if (!(readStrobe && qualSel && !phantom)) return 3'b111;
    if (!interleaved) return addrTop[0] ? 3'b110 : 3'b101;
    if (wideOk()) return 3'b010;
    return addrLsb ? 3'b110 : 3'b101;
  endfunction

  task automatic compareAll();
    string csTag, rdTag, ackTag;
    csTag = (!earlySel || phantom) ? "R4" : (!interleaved ? "R3" :
            (wideOk() ? "R2" : (wideEn ? "R1" : "R10")));
    rdTag = !(readStrobe && qualSel && !phantom) ? "R7" :
            (!interleaved ? "R6" : (wideEn ? "R5" : "R10"));
    ackTag = wideEn ? "R11" : "R10";
    check(csTag, "csN", csN, expCs());
    check(rdTag, "read enables", {rdEvenOutN, rdEvenInN, rdOddInN}, expRd());
    check(ackTag, "wideAckN",
          wideAckN, !(qualSel && !phantom && wideOk()));
    check("R8", "wrOddFromOutN", wrOddFromOutN, !(srcOn == 0));
    check("R8", "wrOddFromInN", wrOddFromInN, !(srcOn == 1));
    check("R9", "no overlap", wrOddFromOutN | wrOddFromInN, 1);
  endtask

  // One cycle: inputs already driven after a falling edge; compare, then advance model.
  task automatic cycle();
    int want;
    #2;
    compareAll();
    want = wideOk() ? 1 : 0;
    @(posedge clk);
    if (srcOn == -1) srcOn = srcTarget;
    else if (want != srcOn) begin
      srcTarget = want;
      srcOn = -1;
    end
    @(negedge clk);
  endtask

  task automatic drive(logic [1:0] at, logic lsb, logic es, logic qs, logic ph,
                       logic rs, logic wr, logic il, logic we);
    addrTop = at; addrLsb = lsb; earlySel = es; qualSel = qs; phantom = ph;
    readStrobe = rs; wideReqN = wr; interleaved = il; wideEn = we;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // reset state (R8: output-bus source on, R4: idle selects)
    check("R8", "reset wrOddFromOutN", wrOddFromOutN, 0);
    check("R4", "reset csN", csN, 4'hF);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R5: interleaved, narrow transfers over every address combination
    for (int i = 0; i < 8; i++) begin
      drive(i[2:1], i[0], 1, 1, 0, 1, 1, 1, 1);
      cycle();
    end
    // R2 / R5 / R11 / R8: wide transfers, source switches through a gap
    for (int i = 0; i < 8; i++) begin
      drive(i[2:1], i[0], 1, 1, 0, 1, 0, 1, 1);
      cycle();
    end
    // R8: back to narrow, gap then output bus
    for (int i = 0; i < 3; i++) begin
      drive(2'b00, 1'b1, 1, 1, 0, 1, 1, 1, 1);
      cycle();
    end
    // R3 / R6: byte-only banks, wide request must be ignored (R10)
    for (int i = 0; i < 8; i++) begin
      drive(i[1:0], i[2], 1, 1, 0, 1, i[2], 0, 1);
      cycle();
    end
    // R10: strap disables wide, request toggles with no effect
    for (int i = 0; i < 8; i++) begin
      drive(i[1:0], i[2], 1, 1, 0, 1, i[0], 1, 0);
      cycle();
    end
    // R4 / R7: phantom and missing selects
    drive(2'b10, 0, 0, 1, 0, 1, 0, 1, 1); cycle();
    drive(2'b10, 0, 1, 1, 1, 1, 0, 1, 1); cycle();
    drive(2'b01, 1, 1, 0, 0, 1, 0, 1, 1); cycle();
    drive(2'b01, 1, 1, 1, 0, 0, 0, 1, 1); cycle();
    // R9: request flips every cycle, gaps chain back to back
    for (int i = 0; i < 10; i++) begin
      drive(2'b11, 0, 1, 1, 0, 1, i[0], 1, 1);
      cycle();
    end
    // mixed random patterns across all requirements
    for (int i = 0; i < 2000; i++) begin
      logic [9:0] r;
      r = 10'($urandom);
      drive(r[1:0], r[2], r[3] | r[9], r[4] | r[8], r[5] & r[6] & r[7],
            r[6], r[7] & r[8], r[8] | r[1], r[9] | r[0]);
      cycle();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule